// File: doc/BRIEF.md
# Memory Alignment Check Unit

This unit sits on the load/store path. It inspects every memory access in the cycle the access is presented. An access at user privilege can be misaligned while two enables are on: the alignment-check flag from the flags register and the alignment-mask bit from the control register. In that case the unit blocks the access before it reaches memory and raises a registered fault request toward the pipeline. The request carries exception vector 17.

An access is misaligned when its address is not a multiple of its size. The request stays up until the pipeline acknowledges it. Only one fault can be outstanding. While a fault is pending, every access presented is blocked, and none of them can start a second fault.

Top module: `align_chk_unit`

## Requirements
- R1: While `ac_flag_i` is 0, no access causes `fault_req_o` to rise, whatever its address, size or privilege.
- R2: An access with `cpl_i` equal to 0, 1 or 2 never causes a fault; only `cpl_i` = 3 can.
- R3: While `am_bit_i` is 0, no access causes a fault, even with `ac_flag_i` = 1 and `cpl_i` = 3.
- R4: The size codes on `size_i` are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A 1-byte access is never misaligned. A 2-byte access is misaligned if address bit 0 is set, a 4-byte access if any of bits 1:0 is set, and an 8-byte access if any of bits 2:0 is set.
- R5: A qualified misaligned access presented with no fault pending sets `fault_req_o` on the next rising clock edge. A qualified access has `ac_flag_i` = 1, `am_bit_i` = 1 and `cpl_i` = 3.
- R6: In the cycle a qualified misaligned access is presented, `suppress_o` is 1 and both `mem_we_o` and `mem_re_o` are 0.
- R7: Once set, `fault_req_o` stays at 1 until a rising edge at which `fault_ack_i` is 1. After that edge it is 0.
- R8: While `fault_req_o` is 1, any valid access is suppressed and produces no strobe. It does not leave a second fault behind, so `fault_req_o` is 0 after the acknowledging edge even if a faulting access arrived meanwhile.
- R9: `fault_vec_o` equals 17 whenever `fault_req_o` is 1 and equals 0 otherwise.
- R10: A valid access that is not suppressed passes straight through in the same cycle: `mem_we_o` = `req_write_i` and `mem_re_o` = not `req_write_i`.
- R11: While `rst_ni` is low, `fault_req_o` is 0 and `fault_vec_o` is 0, including when a fault was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_addr_i | input | ADDR_W | Access byte address |
| size_i | input | 2 | Access size code (see R4) |
| req_write_i | input | 1 | 1 = store, 0 = load |
| cpl_i | input | 2 | Current privilege level |
| ac_flag_i | input | 1 | Alignment-check flag from the flags register |
| am_bit_i | input | 1 | Alignment-mask bit from the control register |
| fault_ack_i | input | 1 | Pipeline accepts the pending fault |
| mem_we_o | output | 1 | Write strobe to memory |
| mem_re_o | output | 1 | Read strobe to memory |
| suppress_o | output | 1 | Current access is blocked |
| fault_req_o | output | 1 | Alignment fault request |
| fault_vec_o | output | 8 | Exception vector, 17 while requesting |

## Verification
The properties assume the pipeline raises `fault_ack_i` only while `fault_req_o` is up. An acknowledge with nothing pending would be meaningless, and the hold and drop properties are written on that assumption. They also assume that `size_i`, `cpl_i` and the two enables are stable for the whole cycle in which they are sampled. The stimulus drives every input on the falling edge. It raises the acknowledge only after it has observed a pending request, and it drops the acknowledge on the following falling edge. It presents accesses both with and without a pending fault, so the blocking path of R8 is reached with that rule respected.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;
  localparam int unsigned SZ_W = 2;
  localparam int unsigned NUM_SIZES = 1 << SZ_W;
  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] ALIGN_FAULT_VEC = 8'd17;
  localparam logic [1:0] USER_CPL = 2'd3;

  typedef enum logic [SZ_W-1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/align_qual.sv
module align_qual
  import align_chk_pkg::*;
(
  input  logic       ac_flag_i,
  input  logic       am_bit_i,
  input  logic [1:0] cpl_i,
  output logic       qual_o
);
  always_comb qual_o = ac_flag_i & am_bit_i & (cpl_i == USER_CPL);
endmodule

// File: rtl/align_detect.sv
module align_detect
  import align_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic              mis_o
);
  logic [ADDR_W-1:0] mask_tab [NUM_SIZES];
  logic [NUM_SIZES-1:0] mis_vec;

  // low-bit mask per size: size code k needs 2^k alignment
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_mask
    assign mask_tab[k] = ADDR_W'((64'd1 << k) - 64'd1);
    assign mis_vec[k]  = |(addr_i & mask_tab[k]);
  end

  always_comb mis_o = mis_vec[size_i];
endmodule

// File: rtl/align_fault_ctl.sv
module align_fault_ctl
  import align_chk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_now_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (pend_q) begin
      if (ack_i) pend_d = 1'b0;
    end else if (fault_now_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign vec_o  = pend_q ? ALIGN_FAULT_VEC : '0;
endmodule

// File: rtl/align_chk_unit.sv
module align_chk_unit
  import align_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        size_i,
  input  logic              req_write_i,
  input  logic [1:0]        cpl_i,
  input  logic              ac_flag_i,
  input  logic              am_bit_i,
  input  logic              fault_ack_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              suppress_o,
  output logic              fault_req_o,
  output logic [7:0]        fault_vec_o
);
  logic qual, mis, pend, fault_now, block;

  align_qual u_qual (
    .ac_flag_i (ac_flag_i),
    .am_bit_i  (am_bit_i),
    .cpl_i     (cpl_i),
    .qual_o    (qual)
  );

  align_detect #(.ADDR_W(ADDR_W)) u_detect (
    .addr_i (req_addr_i),
    .size_i (size_i),
    .mis_o  (mis)
  );

  align_fault_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_now_i (fault_now),
    .ack_i       (fault_ack_i),
    .pend_o      (pend),
    .vec_o       (fault_vec_o)
  );

  always_comb begin
    fault_now  = req_valid_i & qual & mis & ~pend;
    block      = req_valid_i & ((qual & mis) | pend);
    suppress_o = block;
    mem_we_o   = req_valid_i & req_write_i & ~block;
    mem_re_o   = req_valid_i & ~req_write_i & ~block;
  end

  assign fault_req_o = pend;
endmodule

// File: rtl/align_chk_unit_chk.sv
module align_chk_unit_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        size_i,
  input logic              req_write_i,
  input logic [1:0]        cpl_i,
  input logic              ac_flag_i,
  input logic              am_bit_i,
  input logic              fault_ack_i,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              suppress_o,
  input logic              fault_req_o,
  input logic [7:0]        fault_vec_o
);
  logic odd;
  always_comb begin
    case (size_i)
      2'd1:    odd = req_addr_i[0];
      2'd2:    odd = req_addr_i[1] | req_addr_i[0];
      2'd3:    odd = req_addr_i[2] | req_addr_i[1] | req_addr_i[0];
      default: odd = 1'b0;
    endcase
  end

  AST_NO_FAULT_FLAG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_req_o && !ac_flag_i) |=> !fault_req_o); // R1
  AST_NO_FAULT_LOW_CPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_req_o && cpl_i != 2'd3) |=> !fault_req_o); // R2
  AST_NO_FAULT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_req_o && !am_bit_i) |=> !fault_req_o); // R3
  AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_req_o && size_i == 2'd0) |=> !fault_req_o); // R4
  AST_FAULT_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_req_o && req_valid_i && ac_flag_i && am_bit_i && cpl_i == 2'd3 && odd)
    |=> fault_req_o); // R5
  AST_NO_STROBE_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ac_flag_i && am_bit_i && cpl_i == 2'd3 && odd)
    |-> (suppress_o && !mem_we_o && !mem_re_o)); // R6
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_req_o && !fault_ack_i) |=> fault_req_o); // R7
  AST_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_req_o && fault_ack_i) |=> !fault_req_o); // R8
  AST_BLOCK_WHILE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_req_o && req_valid_i) |-> (suppress_o && !mem_we_o && !mem_re_o)); // R8
  AST_VEC_MATCHES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vec_o == (fault_req_o ? 8'd17 : 8'd0)); // R9
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !suppress_o) |-> (mem_we_o == req_write_i && mem_re_o == !req_write_i)); // R10
endmodule

bind align_chk_unit align_chk_unit_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/align_chk_unit_tb_top.sv
module align_chk_unit_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned NVEC = 16;

  // {addr[7:0], size, cpl, ac, am, write, expect_fault}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h01, 2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h07, 2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h01, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h02, 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h02, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h04, 2'd2, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h04, 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h08, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h03, 2'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h03, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h03, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h03, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h06, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h10, 2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hFF, 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'hF0, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] size = 2'd0;
  logic req_write = 1'b0;
  logic [1:0] cpl = 2'd0;
  logic ac_flag = 1'b0;
  logic am_bit = 1'b0;
  logic fault_ack = 1'b0;
  logic mem_we, mem_re, suppress, fault_req;
  logic [7:0] fault_vec;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_chk_unit #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .size_i      (size),
    .req_write_i (req_write),
    .cpl_i       (cpl),
    .ac_flag_i   (ac_flag),
    .am_bit_i    (am_bit),
    .fault_ack_i (fault_ack),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .suppress_o  (suppress),
    .fault_req_o (fault_req),
    .fault_vec_o (fault_vec)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [1:0] s, input logic [1:0] c,
                       input logic ac, input logic am, input logic wr);
    req_valid = 1'b1;
    req_addr  = {24'h00_1234, a};
    size      = s;
    cpl       = c;
    ac_flag   = ac;
    am_bit    = am;
    req_write = wr;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R11", "fault_req in reset", 32'(fault_req), 0);
    check("R11", "fault_vec in reset", 32'(fault_vec), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic exp_f;
      exp_f = VEC[i][0];
      drive(VEC[i][15:8], VEC[i][7:6], VEC[i][5:4], VEC[i][3], VEC[i][2], VEC[i][1]);
      #1;
      // R6 / R10: strobes in the presenting cycle
      check(exp_f ? "R6" : "R10", "suppress", 32'(suppress), 32'(exp_f));
      check(exp_f ? "R6" : "R10", "mem_we", 32'(mem_we), 32'(!exp_f && VEC[i][1]));
      check(exp_f ? "R6" : "R10", "mem_re", 32'(mem_re), 32'(!exp_f && !VEC[i][1]));
      @(negedge clk);
      req_valid = 1'b0;
      // R1 R2 R3 R4 R5 outcome
      check(exp_f ? "R5" : "R4", $sformatf("fault_req vec %0d", i), 32'(fault_req), 32'(exp_f));
      check("R9", "fault_vec", 32'(fault_vec), exp_f ? 32'd17 : 32'd0);
      if (exp_f) begin
        @(negedge clk);
        check("R7", "held without ack", 32'(fault_req), 1);
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        check("R7", "dropped after ack", 32'(fault_req), 0);
        check("R9", "vec cleared", 32'(fault_vec), 0);
      end
    end

    // R8: accesses during pending fault are blocked and not queued
    drive(8'h01, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R8", "pending set", 32'(fault_req), 1);
    drive(8'h00, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0);
    #1;
    check("R8", "aligned read blocked re", 32'(mem_re), 0);
    check("R8", "aligned read suppress", 32'(suppress), 1);
    drive(8'h03, 2'd2, 2'd3, 1'b1, 1'b1, 1'b1);
    fault_ack = 1'b1;
    #1;
    check("R8", "faulting write blocked we", 32'(mem_we), 0);
    @(negedge clk);
    fault_ack = 1'b0;
    req_valid = 1'b0;
    check("R8", "no second fault", 32'(fault_req), 0);
    @(negedge clk);
    check("R8", "still idle", 32'(fault_req), 0);

    // R1: flag off at byte-misaligned 8-byte access
    drive(8'h05, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0);
    #1;
    check("R1", "flag off read passes", 32'(mem_re), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "flag off no fault", 32'(fault_req), 0);

    // R11: reset clears pending fault
    drive(8'h02, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R5", "pending before reset", 32'(fault_req), 1);
    rst_n = 1'b0;
    #1;
    check("R11", "reset clears fault", 32'(fault_req), 0);
    check("R11", "reset clears vec", 32'(fault_vec), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule